// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block is the host side of a passive serial configuration link. It loads a bitstream into a programmable target that cannot fetch its own image. A `start_i` pulse makes it drive the target's active-low configuration request line low for a set time and then release it. It then waits for the target's active-low status line to read high. Next it takes bitstream bytes from a byte stream and shifts them to the target on a data pin, with a data clock that it generates itself. Once the last byte is out, it waits for the target's done line to rise. It then gives the target a few more clock pulses and, when so configured, waits for the init-done line before it reports success.

Open-drain target pins are modelled as a drive-low enable (`cfg_low_o`) and sampled inputs (`status_i`, `done_i`, `initdone_i`). Board pull-ups, bitstream storage and decompression lie outside the block. The byte input is valid/ready. A byte moves on a clock edge where both `dat_valid_i` and `dat_ready_o` are high. `dat_ready_o` is high only while the block waits for the next byte, and it never depends on `dat_valid_i`. The source may hold `dat_valid_i` low for any number of cycles. During such a stall the data clock stays low and no bit is lost. `dat_last_i` marks the final byte and is taken together with that byte.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `cfg_low_o`, `dat_ready_o`, `dclk_o` and `data_o` are all low.
- R2: A `start_i` sampled high drives `cfg_low_o` high from the next cycle for exactly `PULSE_MIN` cycles. `busy_o` is high from that cycle.
- R3: After the request line is released, `dat_ready_o` stays low until `status_i` has been sampled high.
- R4: `dat_ready_o` is high only while a byte is awaited. A byte is taken on an edge with valid and ready both high. While valid is low, the block waits with the data clock low.
- R5: Each byte leaves bit 0 first. Every bit lasts `DIV` cycles: `dclk_o` is low for the first `DIV/2` cycles and high for the rest. `data_o` changes only at the start of a bit period, so it is stable at every rising edge of `dclk_o`.
- R6: If `status_i` is sampled low while a byte is awaited or being shifted, `error_o` is set and the block returns to idle. A byte offered in that cycle is discarded.
- R7: After the last byte, once `done_i` is sampled high, exactly `EXTRA_CLKS` further `dclk_o` pulses follow. If `done_i` stays low for `DONE_TIMEOUT` cycles, `error_o` is set and the block goes idle.
- R8: With `USE_INIT_DONE` set, `done_o` rises and `busy_o` falls only after `initdone_i` is sampled high following the extra pulses.
- R9: `start_i` in any state restarts the sequence with a new request pulse and clears `done_o` and `error_o`.
- R10: Outside the bit-shift phase `data_o` is low, and outside the shift and extra-pulse phases `dclk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin or restart a configuration |
| dat_valid_i | input | 1 | Byte stream valid |
| dat_i | input | DATA_W | Bitstream byte |
| dat_last_i | input | 1 | Marks the final byte |
| dat_ready_o | output | 1 | Byte stream ready |
| cfg_low_o | output | 1 | Drive the request line low |
| status_i | input | 1 | Sampled target status line |
| done_i | input | 1 | Sampled target done line |
| initdone_i | input | 1 | Sampled target init-done line |
| dclk_o | output | 1 | Generated data clock |
| data_o | output | 1 | Serial data to target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last configuration succeeded |
| error_o | output | 1 | Last configuration failed |

## Verification
A normal load sends three bytes with uneven gaps in the valid signal. This separates stalls caused by back-pressure from bit timing, and the bytes captured at each rising clock edge show whether the bits go out in the right order. Three other runs each take a different exit: `done_i` never rising (timeout), `status_i` falling in the middle of a byte (abort), and `start_i` arriving during a shift (restart). These runs separate the error exits from one another and from a clean finish. A behavioural model checks every output in every cycle. In the normal load the init-done wait is held open long enough to show that `done_o` waits for it.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RESET, ST_WAIT_STAT, ST_LOAD,
    ST_SHIFT, ST_WAIT_DONE, ST_EXTRA, ST_WAIT_INIT
  } cfg_state_e;
endpackage

// File: rtl/ps_cfg_phase.sv
// Bit-period phase counter: low half then high half of the data clock.
module ps_cfg_phase #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic high_half,
  output logic period_end
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  logic [PH_W-1:0] ph;

  assign period_end = run && (ph == PH_W'(DIV - 1));
  assign high_half  = run && (ph >= PH_W'(DIV / 2));

  always_ff @(posedge clk) begin
    if (!rst_n)                 ph <= '0;
    else if (!run || period_end) ph <= '0;
    else                        ph <= ph + 1'b1;
  end
endmodule

// File: rtl/ps_cfg_shreg.sv
// Byte serializer, bit 0 first.
module ps_cfg_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         dout,
  output logic         last_bit
);
  localparam int BC_W = (W > 2) ? $clog2(W) : 1;
  logic [W-1:0]    sh;
  logic [BC_W-1:0] idx;

  assign dout     = sh[0];
  assign last_bit = (idx == BC_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= din;
      idx <= '0;
    end else if (shift) begin
      sh  <= {1'b0, sh[W-1:1]};
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/ps_cfg_count.sv
// Shared event counter for pulse width, timeout and extra pulses.
module ps_cfg_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV           = 4,    // >= 2
  parameter int PULSE_MIN     = 8,    // >= 1
  parameter int DONE_TIMEOUT  = 4096, // >= 1
  parameter int EXTRA_CLKS    = 10,   // >= 1
  parameter bit USE_INIT_DONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dat_valid_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              dat_last_i,
  output logic              dat_ready_o,
  output logic              cfg_low_o,
  input  logic              status_i,
  input  logic              done_i,
  input  logic              initdone_i,
  output logic              dclk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int MAX_A  = (PULSE_MIN > DONE_TIMEOUT) ? PULSE_MIN : DONE_TIMEOUT;
  localparam int MAX_V  = (MAX_A > EXTRA_CLKS) ? MAX_A : EXTRA_CLKS;
  localparam int CNT_W  = $clog2(MAX_V + 1);

  cfg_state_e st, st_n;
  logic [CNT_W-1:0] cnt;
  logic cnt_clr, cnt_inc;
  logic run, high_half, period_end;
  logic load, shift, sh_bit, last_bit;
  logic last_q, done_q, err_q, set_done, set_err;
  logic init_ok;

  generate
    if (USE_INIT_DONE) begin : g_init
      assign init_ok = initdone_i;
    end else begin : g_noinit
      assign init_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    st_n     = st;
    set_done = 1'b0;
    set_err  = 1'b0;
    if (start_i) begin
      st_n = ST_RESET;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RESET:
          if (cnt == CNT_W'(PULSE_MIN - 1)) st_n = ST_WAIT_STAT;
        ST_WAIT_STAT:
          if (status_i) st_n = ST_LOAD;
        ST_LOAD:
          if (!status_i) begin
            st_n = ST_IDLE; set_err = 1'b1;
          end else if (dat_valid_i) st_n = ST_SHIFT;
        ST_SHIFT:
          if (!status_i) begin
            st_n = ST_IDLE; set_err = 1'b1;
          end else if (period_end && last_bit)
            st_n = last_q ? ST_WAIT_DONE : ST_LOAD;
        ST_WAIT_DONE:
          if (done_i) st_n = ST_EXTRA;
          else if (cnt == CNT_W'(DONE_TIMEOUT - 1)) begin
            st_n = ST_IDLE; set_err = 1'b1;
          end
        ST_EXTRA:
          if (period_end && cnt == CNT_W'(EXTRA_CLKS - 1)) begin
            if (USE_INIT_DONE) st_n = ST_WAIT_INIT;
            else begin st_n = ST_IDLE; set_done = 1'b1; end
          end
        ST_WAIT_INIT:
          if (init_ok) begin st_n = ST_IDLE; set_done = 1'b1; end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  assign cnt_clr = start_i || (st_n != st);
  assign cnt_inc = (st == ST_RESET) || (st == ST_WAIT_DONE) ||
                   ((st == ST_EXTRA) && period_end);
  assign run     = (st == ST_SHIFT) || (st == ST_EXTRA);
  assign load    = (st == ST_LOAD) && (st_n == ST_SHIFT);
  assign shift   = (st == ST_SHIFT) && period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      last_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st <= st_n;
      if (load) last_q <= dat_last_i;
      if (start_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (set_done) done_q <= 1'b1;
        if (set_err)  err_q  <= 1'b1;
      end
    end
  end

  ps_cfg_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt));

  ps_cfg_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .high_half(high_half), .period_end(period_end));

  ps_cfg_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .din(dat_i), .dout(sh_bit), .last_bit(last_bit));

  assign dat_ready_o = (st == ST_LOAD);
  assign cfg_low_o   = (st == ST_RESET);
  assign dclk_o      = high_half;
  assign data_o      = (st == ST_SHIFT) && sh_bit;
  assign busy_o      = (st != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = err_q;
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic dat_ready_o,
  input logic cfg_low_o,
  input logic dclk_o,
  input logic data_o,
  input logic busy_o,
  input logic done_o,
  input logic error_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cfg_low_o && !dclk_o && !data_o && !dat_ready_o));
  // R10
  req_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_low_o |-> (!dclk_o && !data_o && !dat_ready_o));
  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> $stable(data_o));
  // R4
  ready_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready_o |-> !dclk_o);
  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> !busy_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!busy_o && !error_o));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cfg_low_o && busy_o && !done_o && !error_o));
endmodule

bind ps_cfg_host ps_cfg_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dat_ready_o(dat_ready_o),
  .cfg_low_o(cfg_low_o), .dclk_o(dclk_o), .data_o(data_o), .busy_o(busy_o),
  .done_o(done_o), .error_o(error_o));

// File: tb/sim_ps_cfg_host.sv
module sim_ps_cfg_host;
  localparam int DIV = 4, PULSE = 8, TMO = 40, EXTRA = 10, LAG = 5;
  localparam int S_IDLE = 0, S_RST = 1, S_WST = 2, S_LOAD = 3,
                 S_SHIFT = 4, S_WD = 5, S_EX = 6, S_WI = 7;

  logic clk = 0, rst_n = 0, start_i = 0, dat_valid_i = 0, dat_last_i = 0;
  logic [7:0] dat_i = 0;
  logic status_i = 1, done_i = 0, initdone_i = 0, kill_status = 0;
  logic dat_ready_o, cfg_low_o, dclk_o, data_o, busy_o, done_o, error_o;

  int checks = 0, failures = 0, cycles = 0;

  ps_cfg_host #(.DATA_W(8), .DIV(DIV), .PULSE_MIN(PULSE), .DONE_TIMEOUT(TMO),
                .EXTRA_CLKS(EXTRA), .USE_INIT_DONE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dat_valid_i(dat_valid_i),
    .dat_i(dat_i), .dat_last_i(dat_last_i), .dat_ready_o(dat_ready_o),
    .cfg_low_o(cfg_low_o), .status_i(status_i), .done_i(done_i),
    .initdone_i(initdone_i), .dclk_o(dclk_o), .data_o(data_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Behavioural reference, updated on each rising edge
  int ms = S_IDLE, mc = 0, mp = 0, mb = 0;
  bit mlast = 0, mdone = 0, merr = 0;
  logic [7:0] mbyte = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = S_IDLE; mc = 0; mp = 0; mb = 0; mdone = 0; merr = 0;
    end else if (start_i) begin
      ms = S_RST; mc = 0; mp = 0; mdone = 0; merr = 0;
    end else begin
      case (ms)
        S_RST: if (mc == PULSE - 1) begin ms = S_WST; mc = 0; end else mc++;
        S_WST: if (status_i) ms = S_LOAD;
        S_LOAD:
          if (!status_i) begin ms = S_IDLE; merr = 1; end
          else if (dat_valid_i) begin
            mbyte = dat_i; mlast = dat_last_i; mb = 0; mp = 0; ms = S_SHIFT;
          end
        S_SHIFT:
          if (!status_i) begin ms = S_IDLE; merr = 1; mp = 0; end
          else if (mp == DIV - 1) begin
            mp = 0;
            if (mb == 7) begin ms = mlast ? S_WD : S_LOAD; mc = 0; end
            else mb++;
          end else mp++;
        S_WD:
          if (done_i) begin ms = S_EX; mc = 0; mp = 0; end
          else if (mc == TMO - 1) begin ms = S_IDLE; merr = 1; end
          else mc++;
        S_EX:
          if (mp == DIV - 1) begin
            mp = 0;
            if (mc == EXTRA - 1) ms = S_WI; else mc++;
          end else mp++;
        S_WI: if (initdone_i) begin ms = S_IDLE; mdone = 1; end
        default: ms = S_IDLE;
      endcase
    end
  end

  // Target stand-in: pulls status low during request, releases after LAG
  int scnt = 0;
  always @(negedge clk) begin
    if (cfg_low_o) begin status_i <= 0; scnt = 0; end
    else if (scnt < LAG) scnt++;
    else status_i <= !kill_status;
  end

  // Per-cycle comparison and serial capture
  bit prev_dclk = 0;
  int low_run = 0, last_low_run = 0, pulses = 0, nbits = 0;
  logic [7:0] cur = 0;
  logic [7:0] cap[$];
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_dclk, e_data;
      e_dclk = (ms == S_SHIFT || ms == S_EX) && (mp >= DIV / 2);
      e_data = (ms == S_SHIFT) ? mbyte[mb] : 1'b0;
      chk(cfg_low_o == (ms == S_RST), "R2 cfg_low", cfg_low_o, ms == S_RST);
      chk(dat_ready_o == (ms == S_LOAD), "R4 ready", dat_ready_o, ms == S_LOAD);
      chk(dclk_o == e_dclk, "R5 dclk", dclk_o, e_dclk);
      chk(data_o == e_data, "R5 data", data_o, e_data);
      chk(busy_o == (ms != S_IDLE), "R9 busy", busy_o, ms != S_IDLE);
      chk(done_o == mdone, "R8 done", done_o, mdone);
      chk(error_o == merr, "R6 error", error_o, merr);
    end
    if (cfg_low_o) begin
      low_run++; cap.delete(); nbits = 0; pulses = 0;
    end else if (low_run != 0) begin
      last_low_run = low_run; low_run = 0;
    end
    if (dclk_o && !prev_dclk) begin
      if (done_i) pulses++;
      else begin
        cur[nbits] = data_o; nbits++;
        if (nbits == 8) begin cap.push_back(cur); nbits = 0; end
      end
    end
    prev_dclk = dclk_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      report();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    done_i = 0; initdone_i = 0;
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic wait_status(output bit early_ready);
    early_ready = 0;
    while (cfg_low_o || !status_i) begin
      if (dat_ready_o) early_ready = 1;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit last, input int gap);
    dat_valid_i = 0; tick(gap);
    dat_valid_i = 1; dat_i = b; dat_last_i = last;
    while (!dat_ready_o) @(negedge clk);
    @(negedge clk);
    dat_valid_i = 0;
  endtask

  initial begin
    bit er;
    tick(3); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !error_o && !cfg_low_o && !dat_ready_o && !dclk_o && !data_o,
        "R1 reset outputs", busy_o, 0);

    // Normal load with gaps
    pulse_start();
    wait_status(er);
    chk(last_low_run == PULSE, "R2 pulse width", last_low_run, PULSE);
    chk(!er, "R3 ready before status", er, 0);
    send(8'hA5, 0, 0); send(8'h3C, 0, 3); send(8'h81, 1, 1);
    tick(8 * DIV + 4); done_i = 1;
    tick(EXTRA * DIV + 4);
    chk(pulses == EXTRA, "R7 extra pulses", pulses, EXTRA);
    chk(!done_o && busy_o, "R8 waits for init-done", done_o, 0);
    initdone_i = 1; tick(3);
    chk(done_o && !busy_o, "R8 done after init-done", done_o, 1);
    chk(cap.size() == 3, "R5 byte count", cap.size(), 3);
    if (cap.size() == 3) begin
      chk(cap[0] == 8'hA5, "R5 byte0", cap[0], 8'hA5);
      chk(cap[1] == 8'h3C, "R5 byte1", cap[1], 8'h3C);
      chk(cap[2] == 8'h81, "R5 byte2", cap[2], 8'h81);
    end
    chk(!dclk_o && !data_o, "R10 pins low after", dclk_o, 0);

    // Timeout: done never rises
    pulse_start();
    chk(!done_o, "R9 done cleared", done_o, 0);
    wait_status(er);
    send(8'h0F, 1, 2);
    tick(8 * DIV + TMO + 5);
    chk(error_o && !busy_o, "R7 timeout error", error_o, 1);

    // Status drops mid-byte
    pulse_start();
    wait_status(er);
    dat_valid_i = 1; dat_i = 8'h5A; dat_last_i = 0;
    tick(DIV * 3); dat_valid_i = 0;
    kill_status = 1; tick(3);
    chk(error_o && !busy_o, "R6 status loss", error_o, 1);
    kill_status = 0; tick(LAG + 2);

    // Restart during a shift
    pulse_start();
    chk(!error_o, "R9 error cleared", error_o, 0);
    wait_status(er);
    send(8'hFF, 0, 0);
    tick(5);
    start_i = 1; @(negedge clk); start_i = 0;
    chk(cfg_low_o && busy_o, "R9 restart pulse", cfg_low_o, 1);
    wait_status(er);
    send(8'h12, 0, 0); send(8'h34, 1, 4);
    tick(8 * DIV + 2); done_i = 1;
    tick(EXTRA * DIV + 4); initdone_i = 1; tick(3);
    chk(done_o, "R8 done after restart", done_o, 1);
    chk(cap.size() == 2 && cap[0] == 8'h12 && cap[1] == 8'h34,
        "R5 restart bytes", cap.size(), 2);
    report();
  end
endmodule